// File: doc/BRIEF.md
# Multiplicative Segment-Identifier Scrambler

This block maps a proto segment identifier onto a scrambled virtual segment identifier by computing `(proto × M) mod (2^n − 1)`. Two segment modes are supported: a 256 MB mode with `n = 36` and multiplier 200730139, and a 1 TB mode with `n = 24` and multiplier 12538073. Both multipliers are prime and co-prime to the modulus, so the mapping is one-to-one over the legal proto range. The modulus is taken without a divider. The product is split at bit `n` and the two halves are added. One end-around correction step then turns the sum into the final residue.

The proto identifier is formed inside the block. A request either takes the segment number straight from a kernel effective address, or joins a user context with the segment number of a user effective address. A request enters on a valid/ready handshake. The result leaves three stages later on a second valid/ready handshake, together with the mode it was computed in and a flag that marks a reserved input.

Top module: `vsid_scrambler`

## Requirements
- R1: In 256 MB mode (`in_mode` = 0), `out_vsid` equals `(proto × 200730139) mod (2^36 − 1)`, where the product is exact.
- R2: In 1 TB mode (`in_mode` = 1), `out_vsid[23:0]` equals `(proto × 12538073) mod (2^24 − 1)`, and `out_vsid[35:24]` is zero.
- R3: For a user request (`in_kernel` = 0) in 256 MB mode, proto is `(context << 16) | (ea >> 28)`, keeping only its low 36 bits.
- R4: For a user request in 1 TB mode, proto is `(context << 4) | (ea >> 40)`, keeping only its low 24 bits.
- R5: For a kernel request (`in_kernel` = 1), proto is `ea >> 28` in 256 MB mode and `ea >> 40` in 1 TB mode. `in_context` has no effect on the result.
- R6: When proto equals the reserved all-ones value of the active mode, `out_err` is 1 and `out_vsid` is 0. For every other proto, `out_err` is 0. No result ever equals the all-ones value of its mode.
- R7: A request accepted on clock edge k, with no stall on edges k+1 and k+2, is presented with `out_valid` high after edge k+2. The block can accept one request on every edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_vsid`, `out_err` and `out_mode` keep their values into the next cycle.
- R9: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R10: Results leave in the order their requests were accepted, and `out_mode` repeats the mode of the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request is taken on this edge when in_valid is also high |
| in_mode | input | 1 | 0 = 256 MB segments (n = 36), 1 = 1 TB segments (n = 24) |
| in_kernel | input | 1 | 1 = kernel address, 0 = user context plus address |
| in_context | input | CTX_W (19) | User context number |
| in_ea | input | 64 | Effective address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_vsid | output | 36 | Scrambled identifier, zero-extended in 1 TB mode |
| out_mode | output | 1 | Mode the result was computed in |
| out_err | output | 1 | Proto was the reserved all-ones value |

## Verification
A wrong product or a bad fold shows up as a residue that differs from the exact modular product on the very result that passes through. Because the scramble is one-to-one, almost every such fault changes the output word. A broken end-around correction shows up only at the edges of the range: on proto values whose folded sum lands on or just past the all-ones value, and on the reserved input itself. It appears as an all-ones result or a missing error flag. A stage-enable or valid fault shows up within three cycles, as a result that arrives at the wrong cycle, is lost, is repeated, or changes while the consumer is stalling.

// File: rtl/vsid_pkg.sv
// Shared constants and helpers for the segment-identifier scrambler.
// Assumes the product of a 36-bit proto and a 28-bit multiplier fits 64 bits.
package vsid_pkg;

    typedef enum logic {
        SEG_256M = 1'b0,
        SEG_1T   = 1'b1
    } seg_mode_e;

    localparam int VSID_W   = 36;
    localparam int EA_W     = 64;
    localparam int MULT_W   = 28;
    localparam int PROD_W   = VSID_W + MULT_W;
    localparam int FOLD_W   = VSID_W + 1;

    localparam int BITS_256M = 36;
    localparam int BITS_1T   = 24;

    localparam int ESID_SH_256M = 28;
    localparam int ESID_SH_1T   = 40;
    localparam int UCTX_SH_256M = 16;
    localparam int UCTX_SH_1T   = 4;

    localparam logic [MULT_W-1:0] MULT_256M = 28'd200730139;
    localparam logic [MULT_W-1:0] MULT_1T   = 28'd12538073;

    // All-ones modulus of the chosen mode, zero-extended to VSID_W.
    function automatic logic [VSID_W-1:0] seg_mask(input seg_mode_e m);
        return (m == SEG_1T) ? VSID_W'((64'd1 << BITS_1T) - 64'd1)
                             : VSID_W'((64'd1 << BITS_256M) - 64'd1);
    endfunction

    // Multiplier of the chosen mode.
    function automatic logic [MULT_W-1:0] seg_mult(input seg_mode_e m);
        return (m == SEG_1T) ? MULT_1T : MULT_256M;
    endfunction

endpackage

// File: rtl/vsid_proto_build.sv
// Forms the proto identifier from a request, without registers.
// Kernel requests use the address segment number. User requests join the
// context above it. The result is cut to the mode width, and the reserved
// all-ones value is flagged.
// Assumes CTX_W + 16 <= 36, so the context shift is a plain zero-extension.
module vsid_proto_build
    import vsid_pkg::*;
#(
    parameter int CTX_W = 19
) (
    input  seg_mode_e            mode,
    input  logic                 kernel,
    input  logic [CTX_W-1:0]     ctx,
    input  logic [EA_W-1:0]      ea,
    output logic [VSID_W-1:0]    proto,
    output logic                 reserved
);
    logic [VSID_W-1:0] esid_256m;
    logic [VSID_W-1:0] esid_1t;
    logic [VSID_W-1:0] raw;
    logic [VSID_W-1:0] mask;
    logic              unused_ea_low;

    // Segment numbers of the effective address for both segment sizes.
    always_comb begin
        esid_256m = ea[EA_W-1:ESID_SH_256M];
        esid_1t   = VSID_W'(ea[EA_W-1:ESID_SH_1T]);
    end

    // The offset bits below the segment number do not enter the proto.
    assign unused_ea_low = ^ea[ESID_SH_256M-1:0];

    // Choose the kernel or user form, then cut to the mode width.
    always_comb begin
        mask = seg_mask(mode);
        if (kernel)
            raw = (mode == SEG_1T) ? esid_1t : esid_256m;
        else if (mode == SEG_1T)
            raw = (VSID_W'(ctx) << UCTX_SH_1T) | esid_1t;
        else
            raw = (VSID_W'(ctx) << UCTX_SH_256M) | esid_256m;
        proto    = raw & mask;
        reserved = (proto == mask);
    end
endmodule

// File: rtl/vsid_mul_stage.sv
// Stage 1: registers the exact product of proto and the mode multiplier.
// Assumes the enable is the common advance signal of the pipeline.
module vsid_mul_stage
    import vsid_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 in_valid,
    input  seg_mode_e            in_mode,
    input  logic                 in_err,
    input  logic [VSID_W-1:0]    proto,
    output logic                 s_valid,
    output seg_mode_e            s_mode,
    output logic                 s_err,
    output logic [PROD_W-1:0]    s_prod
);
    logic [PROD_W-1:0] prod;

    // Exact product; the multiplier is picked by mode.
    assign prod = PROD_W'(proto) * PROD_W'(seg_mult(in_mode));

    // Hold the product and tags when the pipeline advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_mode  <= SEG_256M;
            s_err   <= 1'b0;
            s_prod  <= '0;
        end else if (adv) begin
            s_valid <= in_valid;
            s_mode  <= in_mode;
            s_err   <= in_err;
            s_prod  <= prod;
        end
    end
endmodule

// File: rtl/vsid_fold_stage.sv
// Stage 2: adds the bits above n to the bits below n.
// Assumes that in 1 TB mode the product is below 2^48, because both
// factors are below 2^24.
module vsid_fold_stage
    import vsid_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 in_valid,
    input  seg_mode_e            in_mode,
    input  logic                 in_err,
    input  logic [PROD_W-1:0]    prod,
    output logic                 s_valid,
    output seg_mode_e            s_mode,
    output logic                 s_err,
    output logic [FOLD_W-1:0]    s_fold
);
    logic [FOLD_W-1:0] fold_256m;
    logic [FOLD_W-1:0] fold_1t;

    // High part plus low part for both split points.
    always_comb begin
        fold_256m = FOLD_W'(prod[PROD_W-1:BITS_256M]) + FOLD_W'(prod[BITS_256M-1:0]);
        fold_1t   = FOLD_W'(prod[2*BITS_1T-1:BITS_1T]) + FOLD_W'(prod[BITS_1T-1:0]);
    end

    // Hold the folded sum and tags when the pipeline advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_mode  <= SEG_256M;
            s_err   <= 1'b0;
            s_fold  <= '0;
        end else if (adv) begin
            s_valid <= in_valid;
            s_mode  <= in_mode;
            s_err   <= in_err;
            s_fold  <= (in_mode == SEG_1T) ? fold_1t : fold_256m;
        end
    end
endmodule

// File: rtl/vsid_fix_stage.sv
// Stage 3: end-around correction of the folded sum.
// When the sum is at or above 2^n - 1, adding one carries into bit n.
// Adding that carry and keeping n bits gives the residue.
// Assumes the folded sum is below 2^(n+1) - 1.
module vsid_fix_stage
    import vsid_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 in_valid,
    input  seg_mode_e            in_mode,
    input  logic                 in_err,
    input  logic [FOLD_W-1:0]    fold,
    output logic                 s_valid,
    output seg_mode_e            s_mode,
    output logic                 s_err,
    output logic [VSID_W-1:0]    s_vsid
);
    logic              carry;
    logic [VSID_W-1:0] fixed;

    // Detect a sum at or above the all-ones value of the mode.
    always_comb begin
        if (in_mode == SEG_1T)
            carry = (|fold[FOLD_W-1:BITS_1T]) | (&fold[BITS_1T-1:0]);
        else
            carry = fold[BITS_256M] | (&fold[BITS_256M-1:0]);
        fixed = VSID_W'(fold + FOLD_W'(carry)) & seg_mask(in_mode);
    end

    // Hold the final identifier and tags when the pipeline advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_mode  <= SEG_256M;
            s_err   <= 1'b0;
            s_vsid  <= '0;
        end else if (adv) begin
            s_valid <= in_valid;
            s_mode  <= in_mode;
            s_err   <= in_err;
            s_vsid  <= fixed;
        end
    end
endmodule

// File: rtl/vsid_scrambler.sv
// Top of the segment-identifier scrambler. It has three registered stages
// (multiply, fold, correct) that share one advance signal. The advance
// signal is high unless the output holds a result that the consumer has
// not taken.
// Assumes rst_n is synchronous and active low.
module vsid_scrambler
    import vsid_pkg::*;
#(
    parameter int CTX_W = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_mode,
    input  logic                 in_kernel,
    input  logic [CTX_W-1:0]     in_context,
    input  logic [EA_W-1:0]      in_ea,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [VSID_W-1:0]    out_vsid,
    output logic                 out_mode,
    output logic                 out_err
);
    seg_mode_e         mode_in;
    logic [VSID_W-1:0] proto;
    logic              reserved;
    logic              adv;

    logic              s1_valid, s2_valid, s3_valid;
    seg_mode_e         s1_mode, s2_mode, s3_mode;
    logic              s1_err, s2_err, s3_err;
    logic [PROD_W-1:0] s1_prod;
    logic [FOLD_W-1:0] s2_fold;
    logic [VSID_W-1:0] s3_vsid;

    // Decode the mode pin into the shared enum.
    assign mode_in = seg_mode_e'(in_mode);

    // Advance whenever the output slot is free or is being drained.
    assign adv      = !s3_valid || out_ready;
    assign in_ready = adv;

    vsid_proto_build #(.CTX_W(CTX_W)) u_proto (
        .mode     (mode_in),
        .kernel   (in_kernel),
        .ctx      (in_context),
        .ea       (in_ea),
        .proto    (proto),
        .reserved (reserved)
    );

    vsid_mul_stage u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .in_valid (in_valid),
        .in_mode  (mode_in),
        .in_err   (reserved),
        .proto    (proto),
        .s_valid  (s1_valid),
        .s_mode   (s1_mode),
        .s_err    (s1_err),
        .s_prod   (s1_prod)
    );

    vsid_fold_stage u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .in_valid (s1_valid),
        .in_mode  (s1_mode),
        .in_err   (s1_err),
        .prod     (s1_prod),
        .s_valid  (s2_valid),
        .s_mode   (s2_mode),
        .s_err    (s2_err),
        .s_fold   (s2_fold)
    );

    vsid_fix_stage u_fix (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .in_valid (s2_valid),
        .in_mode  (s2_mode),
        .in_err   (s2_err),
        .fold     (s2_fold),
        .s_valid  (s3_valid),
        .s_mode   (s3_mode),
        .s_err    (s3_err),
        .s_vsid   (s3_vsid)
    );

    // Drive the result ports from the last stage.
    assign out_valid = s3_valid;
    assign out_vsid  = s3_vsid;
    assign out_mode  = logic'(s3_mode);
    assign out_err   = s3_err;
endmodule

// File: rtl/vsid_scrambler_chk.sv
// Port-level properties of the scrambler, attached by bind.
module vsid_scrambler_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [35:0] out_vsid,
    input logic        out_mode,
    input logic        out_err
);
    AST_NO_ALLONES_256M: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_mode) |-> (out_vsid != 36'hFFFFFFFFF));             // R1

    AST_NARROW_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode) |-> (out_vsid[35:24] == 12'd0 && out_vsid[23:0] != 24'hFFFFFF)); // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_vsid == 36'd0));                        // R6

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(in_valid && in_ready, 3) && $past(in_ready, 2)
         && $past(in_ready, 1)) |-> out_valid);                                 // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vsid)
                                       && $stable(out_err) && $stable(out_mode))); // R8

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);                               // R8

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> !out_valid);                                                 // R9
endmodule

bind vsid_scrambler vsid_scrambler_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vsid  (out_vsid),
    .out_mode  (out_mode),
    .out_err   (out_err)
);

// File: tb/tb_vsid_scrambler.sv
module tb_vsid_scrambler;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_mode = 1'b0;
    logic        in_kernel = 1'b0;
    logic [18:0] in_context = '0;
    logic [63:0] in_ea = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [35:0] out_vsid;
    logic        out_mode;
    logic        out_err;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit lat_chk = 1'b0;
    bit stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [35:0] q_vsid[$];
    logic        q_err[$];
    logic        q_mode[$];
    int          q_fire[$];
    string       q_tag[$];

    vsid_scrambler dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_kernel(in_kernel), .in_context(in_context),
        .in_ea(in_ea), .out_valid(out_valid), .out_ready(out_ready),
        .out_vsid(out_vsid), .out_mode(out_mode), .out_err(out_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference: proto per R3/R4/R5, exact product reduced with a true modulo.
    task automatic model(input logic mode, input logic kern, input logic [18:0] ctx,
                         input logic [63:0] ea, output logic [35:0] v, output logic e);
        logic [63:0]  mask;
        logic [63:0]  proto;
        logic [127:0] p;
        mask = mode ? 64'hFFFFFF : 64'hF_FFFF_FFFF;
        if (kern) proto = mode ? (ea >> 40) : (ea >> 28);
        else      proto = mode ? ((64'(ctx) << 4) | (ea >> 40)) : ((64'(ctx) << 16) | (ea >> 28));
        proto = proto & mask;
        e = (proto == mask);
        p = 128'(proto) * (mode ? 128'd12538073 : 128'd200730139);
        p = p % 128'(mask);
        v = p[35:0];
    endtask

    // Driver: present one request, wait for acceptance, push the expectation.
    task automatic send(input logic mode, input logic kern, input logic [18:0] ctx,
                        input logic [63:0] ea, input string tag);
        logic [35:0] v;
        logic        e;
        @(negedge clk);
        in_valid = 1'b1; in_mode = mode; in_kernel = kern; in_context = ctx; in_ea = ea;
        while (!in_ready) @(negedge clk);
        model(mode, kern, ctx, ea, v, e);
        q_vsid.push_back(v); q_err.push_back(e); q_mode.push_back(mode);
        q_fire.push_back(cyc + 1); q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Consumer: ready always high, or a pseudo-random pattern in the stall phase.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_en ? (lfsr[0] | lfsr[5]) : 1'b1;
    end

    // Monitor: pop and compare each result that is taken; check stall holding.
    bit          stall_prev = 1'b0;
    logic [35:0] prev_vsid;
    logic        prev_err, prev_mode;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev) begin
                check(out_valid && out_vsid == prev_vsid && out_err == prev_err
                      && out_mode == prev_mode, "R8 hold", {27'd0, out_valid, out_vsid}, {28'd1, prev_vsid});
            end
            if (out_valid && !out_ready)
                check(!in_ready, "R8 in_ready low", 64'(in_ready), 64'd0);
            if (out_valid && out_ready) begin
                if (q_vsid.size() == 0) begin
                    check(1'b0, "R10 unexpected result", 64'(out_vsid), 64'd0);
                end else begin
                    logic [35:0] ev;
                    logic        ee, em;
                    int          ef;
                    string       tg;
                    ev = q_vsid.pop_front(); ee = q_err.pop_front(); em = q_mode.pop_front();
                    ef = q_fire.pop_front(); tg = q_tag.pop_front();
                    check(out_vsid == ev, {tg, " vsid"}, 64'(out_vsid), 64'(ev));
                    check(out_err == ee, {tg, " R6 err"}, 64'(out_err), 64'(ee));
                    check(out_mode == em, {tg, " R10 mode"}, 64'(out_mode), 64'(em));
                    if (lat_chk) check(cyc == ef + 2, {tg, " R7 latency"}, 64'(cyc), 64'(ef + 2));
                end
            end
            stall_prev = out_valid && !out_ready;
            prev_vsid = out_vsid; prev_err = out_err; prev_mode = out_mode;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc >= WATCHDOG);
        check(1'b0, "watchdog", 64'(cyc), 64'(WATCHDOG));
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!out_valid && in_ready, "R9 in reset", {62'd0, out_valid, in_ready}, 64'd1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R9 after reset", {62'd0, out_valid, in_ready}, 64'd1);

        // Directed phase, no stalls, latency checked (R7).
        lat_chk = 1'b1;
        send(1'b0, 1'b1, 19'd0,       64'hC000_0000_0000_0000, "R1 R5 kernel 256M");
        send(1'b0, 1'b0, 19'd5,       64'h0000_0123_4000_0000, "R1 R3 user 256M");
        send(1'b1, 1'b0, 19'h12345,   64'h0000_0A00_0000_0000, "R2 R4 user 1T");
        send(1'b1, 1'b1, 19'd0,       64'hC000_0012_3456_789A, "R2 R5 kernel 1T");
        send(1'b1, 1'b1, 19'h7FFFF,   64'hC000_0012_3456_789A, "R5 context ignored");
        send(1'b0, 1'b1, 19'd0,       64'hFFFF_FFFF_F000_0000, "R6 reserved 256M");
        send(1'b1, 1'b1, 19'd0,       64'hFFFF_FF00_0000_0000, "R6 reserved 1T");
        send(1'b0, 1'b1, 19'd0,       64'hFFFF_FFFF_E000_0000, "R1 below reserved");
        send(1'b1, 1'b1, 19'd0,       64'hFFFF_FE00_0000_0000, "R2 below reserved");
        send(1'b0, 1'b1, 19'd0,       64'h0,                   "R1 zero proto");
        send(1'b0, 1'b0, 19'h7FFFF,   64'hFFFF_FFFF_FFFF_FFFF, "R3 R6 truncated user");
        send(1'b1, 1'b0, 19'h7FFFF,   64'h0000_0000_0000_0000, "R4 truncated user");
        idle();
        repeat (6) @(negedge clk);
        send(1'b0, 1'b0, 19'd1,       64'h0000_0001_0000_0000, "R7 single after gap");
        idle();
        repeat (6) @(negedge clk);

        // Stall phase with mixed modes and random operands (R8, R10).
        lat_chk = 1'b0;
        stall_en = 1'b1;
        for (int i = 0; i < 300; i++) begin
            logic [63:0] ea;
            ea = {$urandom, $urandom};
            send(1'(i % 2), 1'((i / 3) % 2), 19'($urandom), ea, "R1 R2 R8 R10 random");
            if (i % 7 == 0) idle();
        end
        idle();
        while (q_vsid.size() != 0) @(negedge clk);
        stall_en = 1'b0;
        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule